// File: doc/BRIEF.md
# Fan Supervisor State Machine

This block sequences a low-frequency PWM fan controller through four operating states: shutdown, sleep, startup and normal. It takes already-digitised codes for a primary control input (normally a thermistor divider), a secondary control input and a sleep threshold, together with a single-cycle tick that marks each PWM period. From these it drives an enable and a force-high request to a separate PWM modulator, an indication that the fan driver pin should be released (high impedance), and an active-low overtemperature flag.

The primary input also acts as a shutdown and reset line. Pulling it below a low code stops everything at once, whatever the other input does. Raising it above a higher code restarts the block as if from power-up. Every time the fan goes from off to running, the modulator output is held fully on for a fixed number of PWM periods so that a stopped fan spins up reliably. When both inputs are cold the fan is put to sleep. It wakes only when an input climbs a fixed hysteresis above the sleep threshold. All thresholds are parameters expressed in input code units.

Top module: `fan_supervisor`

## Requirements
- R1: While rst_n is low, and after it is released, the block is in the shutdown state: pwm_en=0, pwm_force_hi=0, out_float=1, ot_fault_n=1.
- R2: Whenever prim_code < SHUT_LO (default 36), all four outputs take their shutdown values (pwm_en=0, pwm_force_hi=0, out_float=1, ot_fault_n=1) in the same cycle, combinationally and whatever sec_code holds. The state becomes shutdown at the next clock edge, from any state.
- R3: The shutdown state is left only at a clock edge where prim_code > START_HI (default 56). A code equal to START_HI, or any code between the two thresholds, keeps the block in shutdown with its outputs off.
- R4: On leaving shutdown, the block goes to startup if the wake condition of R8 holds, and to sleep otherwise.
- R5: In startup, pwm_en=1, pwm_force_hi=1 and out_float=0. Startup lasts exactly STARTUP_PERIODS (default 64) clock edges at which period_tick=1, and then the block moves to normal.
- R6: In normal, pwm_en=1, pwm_force_hi=0 and out_float=0, so the modulator controls the duty cycle.
- R7: In normal, with sleep_code != 0, prim_code < sleep_code and sec_code < sleep_code, the block moves to sleep at the next edge. In sleep, pwm_en=0, pwm_force_hi=0, out_float=1 and ot_fault_n=1.
- R8: Sleep is left for startup at the first edge where prim_code or sec_code is strictly greater than sleep_code + HYST (default HYST 28, computed without overflow). An input equal to that level does not wake the block.
- R9: sleep_code = 0 disables sleep. The block never enters sleep, and the wake condition is taken as true.
- R10: ot_fault_n goes low one cycle after prim_code > OT_THR (default 196) is seen while the block is or becomes startup or normal. It returns high one cycle after the code falls to OT_THR or below. pwm_en is unaffected. OT_THR must exceed the full-duty code PWM_FULL_THR (default 179) and START_HI must exceed SHUT_LO; elaboration rejects other settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| prim_code | input | CODE_W | Primary control input code (also the shutdown/reset line) |
| sec_code | input | CODE_W | Secondary control input code |
| sleep_code | input | CODE_W | Sleep threshold code; zero disables sleep |
| period_tick | input | 1 | One-cycle pulse per PWM period |
| pwm_en | output | 1 | Modulator enable |
| pwm_force_hi | output | 1 | Force modulator output fully on |
| out_float | output | 1 | Release the fan driver pin |
| ot_fault_n | output | 1 | Overtemperature flag, active low |

## Verification
Several properties are checked on every cycle: the combinational shutdown override, the quiet outputs in sleep, forced drive throughout startup, startup holding across cycles without a tick, staying in shutdown at or below the release code, sleep being unreachable with a zero threshold, wake-up above the hysteresis level, and the overtemperature flag tracking its input. Other behaviours can only be shown by the bench's scenarios against its reference model: the exact count of 64 ticks in startup, the choice between sleep and startup on release from shutdown, the equality boundaries of the wake, release and fault codes, and long random sequences that mix shutdown with sleep.

// File: rtl/fansup_pkg.sv
`timescale 1ns/1ps
package fansup_pkg;

    typedef enum logic [1:0] {
        ST_SHUTDOWN = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_STARTUP  = 2'd2,
        ST_NORMAL   = 2'd3
    } fan_state_e;

    typedef struct packed {
        logic shut_now;    // primary below the low shutdown code
        logic release_ok;  // primary above the startup code
        logic sleep_hit;   // both inputs below a non-zero sleep threshold
        logic wake_ok;     // an input above threshold + hysteresis, or sleep disabled
        logic over_temp;   // primary above the fault code
    } lvl_flags_t;

endpackage

// File: rtl/fansup_level_cmp.sv
`timescale 1ns/1ps
module fansup_level_cmp
    import fansup_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SHUT_LO  = 36,
    parameter int START_HI = 56,
    parameter int OT_THR   = 196,
    parameter int HYST     = 28
) (
    input  logic [CODE_W-1:0] prim_code,
    input  logic [CODE_W-1:0] sec_code,
    input  logic [CODE_W-1:0] sleep_code,
    output lvl_flags_t        flags
);
    localparam logic [CODE_W-1:0] LO_C   = CODE_W'(SHUT_LO);
    localparam logic [CODE_W-1:0] HI_C   = CODE_W'(START_HI);
    localparam logic [CODE_W-1:0] OT_C   = CODE_W'(OT_THR);
    localparam logic [CODE_W:0]   HYST_C = (CODE_W+1)'(HYST);

    logic [CODE_W:0] wake_lvl;
    logic            sleep_off;

    always_comb begin
        wake_lvl        = {1'b0, sleep_code} + HYST_C;
        sleep_off       = (sleep_code == '0);
        flags.shut_now  = (prim_code < LO_C);
        flags.release_ok = (prim_code > HI_C);
        flags.sleep_hit = !sleep_off && (prim_code < sleep_code) && (sec_code < sleep_code);
        flags.wake_ok   = sleep_off
                        || ({1'b0, prim_code} > wake_lvl)
                        || ({1'b0, sec_code}  > wake_lvl);
        flags.over_temp = (prim_code > OT_C);
    end
endmodule

// File: rtl/fansup_seq.sv
`timescale 1ns/1ps
module fansup_seq
    import fansup_pkg::*;
#(
    parameter int STARTUP_PERIODS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  lvl_flags_t flags,
    input  logic       period_tick,
    output fan_state_e state_q,
    output logic       fault_q
);
    localparam int CNT_W = (STARTUP_PERIODS > 1) ? $clog2(STARTUP_PERIODS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_PERIODS - 1);

    typedef struct packed {
        fan_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (flags.shut_now) begin
            nxt_d.state = ST_SHUTDOWN;
            nxt_d.cnt   = '0;
        end else begin
            unique case (cur_q.state)
                ST_SHUTDOWN: begin
                    if (flags.release_ok) begin
                        nxt_d.state = flags.wake_ok ? ST_STARTUP : ST_SLEEP;
                        nxt_d.cnt   = '0;
                    end
                end
                ST_SLEEP: begin
                    if (flags.wake_ok) begin
                        nxt_d.state = ST_STARTUP;
                        nxt_d.cnt   = '0;
                    end
                end
                ST_STARTUP: begin
                    if (period_tick) begin
                        if (cur_q.cnt == CNT_LAST) begin
                            nxt_d.state = ST_NORMAL;
                            nxt_d.cnt   = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                end
                ST_NORMAL: begin
                    if (flags.sleep_hit) nxt_d.state = ST_SLEEP;
                end
                default: nxt_d.state = ST_SHUTDOWN;
            endcase
        end
        nxt_d.fault = flags.over_temp && !flags.shut_now
                   && ((nxt_d.state == ST_STARTUP) || (nxt_d.state == ST_NORMAL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_SHUTDOWN, cnt: '0, fault: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_q = cur_q.state;
    assign fault_q = cur_q.fault;
endmodule

// File: rtl/fansup_drive.sv
`timescale 1ns/1ps
module fansup_drive
    import fansup_pkg::*;
(
    input  fan_state_e state_q,
    input  logic       fault_q,
    input  logic       shut_now,
    output logic       pwm_en,
    output logic       pwm_force_hi,
    output logic       out_float,
    output logic       ot_fault_n
);
    logic running;

    always_comb begin
        running      = !shut_now && ((state_q == ST_STARTUP) || (state_q == ST_NORMAL));
        pwm_en       = running;
        pwm_force_hi = running && (state_q == ST_STARTUP);
        out_float    = !running;
        ot_fault_n   = !(running && fault_q);
    end
endmodule

// File: rtl/fan_supervisor.sv
`timescale 1ns/1ps
module fan_supervisor
    import fansup_pkg::*;
#(
    parameter int CODE_W          = 8,
    parameter int SHUT_LO         = 36,
    parameter int START_HI        = 56,
    parameter int PWM_FULL_THR    = 179,
    parameter int OT_THR          = 196,
    parameter int HYST            = 28,
    parameter int STARTUP_PERIODS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] prim_code,
    input  logic [CODE_W-1:0] sec_code,
    input  logic [CODE_W-1:0] sleep_code,
    input  logic              period_tick,
    output logic              pwm_en,
    output logic              pwm_force_hi,
    output logic              out_float,
    output logic              ot_fault_n
);
    generate
        if ((OT_THR <= PWM_FULL_THR) || (START_HI <= SHUT_LO)) begin : g_bad_cfg
            $error("fan_supervisor: fault code must exceed full-duty code and release code must exceed shutdown code");
        end
    endgenerate

    lvl_flags_t flags;
    fan_state_e st_q;
    logic       fault_q;

    fansup_level_cmp #(
        .CODE_W  (CODE_W),
        .SHUT_LO (SHUT_LO),
        .START_HI(START_HI),
        .OT_THR  (OT_THR),
        .HYST    (HYST)
    ) u_cmp (
        .prim_code (prim_code),
        .sec_code  (sec_code),
        .sleep_code(sleep_code),
        .flags     (flags)
    );

    fansup_seq #(
        .STARTUP_PERIODS(STARTUP_PERIODS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (flags),
        .period_tick(period_tick),
        .state_q    (st_q),
        .fault_q    (fault_q)
    );

    fansup_drive u_drv (
        .state_q     (st_q),
        .fault_q     (fault_q),
        .shut_now    (flags.shut_now),
        .pwm_en      (pwm_en),
        .pwm_force_hi(pwm_force_hi),
        .out_float   (out_float),
        .ot_fault_n  (ot_fault_n)
    );
endmodule

// File: rtl/fan_supervisor_chk.sv
`timescale 1ns/1ps
module fan_supervisor_chk
    import fansup_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SHUT_LO  = 36,
    parameter int START_HI = 56,
    parameter int OT_THR   = 196,
    parameter int HYST     = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] prim_code,
    input logic [CODE_W-1:0] sec_code,
    input logic [CODE_W-1:0] sleep_code,
    input logic              period_tick,
    input logic              pwm_en,
    input logic              pwm_force_hi,
    input logic              out_float,
    input logic              ot_fault_n,
    input fan_state_e        st_q
);
    localparam logic [CODE_W-1:0] LO_C = CODE_W'(SHUT_LO);
    localparam logic [CODE_W-1:0] HI_C = CODE_W'(START_HI);
    localparam logic [CODE_W-1:0] OT_C = CODE_W'(OT_THR);

    logic [CODE_W:0] wake_level;
    assign wake_level = {1'b0, sleep_code} + (CODE_W+1)'(HYST);

    // R2: shutdown override on the outputs
    p_shutdown_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_code < LO_C) |-> (!pwm_en && !pwm_force_hi && out_float && ot_fault_n));

    // R3: no release at or below the startup code
    p_stay_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHUTDOWN && prim_code <= HI_C) |=> (st_q == ST_SHUTDOWN));

    // R5: forced drive throughout startup
    p_startup_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STARTUP && prim_code >= LO_C) |-> (pwm_en && pwm_force_hi && !out_float));

    // R5: startup does not advance without a tick
    p_startup_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STARTUP && !period_tick && prim_code >= LO_C) |=> (st_q == ST_STARTUP));

    // R7: sleep keeps everything quiet
    p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP) |-> (!pwm_en && !pwm_force_hi && out_float && ot_fault_n));

    // R8: wake above the hysteresis level
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && prim_code >= LO_C
         && ({1'b0, prim_code} > wake_level || {1'b0, sec_code} > wake_level))
        |=> (st_q == ST_STARTUP));

    // R9: zero threshold keeps sleep unreachable
    p_no_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_code == '0 && st_q != ST_SLEEP) |=> (st_q != ST_SLEEP));

    // R10: flag only follows a hot primary input
    p_fault_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ot_fault_n) |-> ($past(prim_code) > OT_C));

    // R10: hot primary in normal raises the flag
    p_fault_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL && prim_code > OT_C) |=> (!ot_fault_n || prim_code < LO_C));
endmodule

bind fan_supervisor fan_supervisor_chk #(
    .CODE_W  (CODE_W),
    .SHUT_LO (SHUT_LO),
    .START_HI(START_HI),
    .OT_THR  (OT_THR),
    .HYST    (HYST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prim_code   (prim_code),
    .sec_code    (sec_code),
    .sleep_code  (sleep_code),
    .period_tick (period_tick),
    .pwm_en      (pwm_en),
    .pwm_force_hi(pwm_force_hi),
    .out_float   (out_float),
    .ot_fault_n  (ot_fault_n),
    .st_q        (st_q)
);

// File: tb/test_fan_supervisor.sv
`timescale 1ns/1ps
module test_fan_supervisor;
    localparam int LO = 36, HI = 56, OT = 196, HY = 28, NPER = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prim_code = '0, sec_code = '0, sleep_code = '0;
    logic       period_tick = 1'b0;
    logic       pwm_en, pwm_force_hi, out_float, ot_fault_n;

    int  checks = 0, failures = 0;
    bit  cmp_on = 1'b0, done = 1'b0;

    // reference model: 0 shutdown, 1 sleep, 2 startup, 3 normal
    int  m_st = 0, m_cnt = 0;
    bit  m_fault = 1'b0;

    always #4 clk = ~clk;

    fan_supervisor i_fan_supervisor (
        .clk(clk), .rst_n(rst_n), .prim_code(prim_code), .sec_code(sec_code),
        .sleep_code(sleep_code), .period_tick(period_tick), .pwm_en(pwm_en),
        .pwm_force_hi(pwm_force_hi), .out_float(out_float), .ot_fault_n(ot_fault_n)
    );

    function automatic bit wake_cond(int p, int s, int t);
        return (t == 0) || (p > t + HY) || (s > t + HY);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_fault <= 1'b0;
        end else begin
            int st, cn;
            st = m_st; cn = m_cnt;
            if (prim_code < LO) begin
                st = 0; cn = 0;
            end else begin
                case (m_st)
                    0: if (prim_code > HI) begin
                           st = wake_cond(prim_code, sec_code, sleep_code) ? 2 : 1; cn = 0;
                       end
                    1: if (wake_cond(prim_code, sec_code, sleep_code)) begin st = 2; cn = 0; end
                    2: if (period_tick) begin
                           if (cn == NPER - 1) begin st = 3; cn = 0; end else cn = cn + 1;
                       end
                    default: if (sleep_code != 0 && prim_code < sleep_code && sec_code < sleep_code) st = 1;
                endcase
            end
            m_st <= st; m_cnt <= cn;
            m_fault <= (prim_code > OT) && (st >= 2);
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b @%0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit run, shut;
            string tag;
            #2;
            shut = (prim_code < LO);
            run  = !shut && (m_st >= 2);
            if (shut)            tag = "R2";
            else if (m_st == 0)  tag = "R3";
            else if (m_st == 1)  tag = "R7";
            else if (m_st == 2)  tag = "R5";
            else                 tag = "R6";
            chk(tag, "pwm_en", pwm_en, run);
            chk(tag, "pwm_force_hi", pwm_force_hi, run && m_st == 2);
            chk(tag, "out_float", out_float, !run);
            chk("R10", "ot_fault_n", ot_fault_n, !(run && m_fault));
        end
    end

    task automatic at_neg();
        @(negedge clk); #3;
    endtask

    task automatic wait_n(int n);
        repeat (n) at_neg();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        at_neg();
        // R1: reset values
        chk("R1", "pwm_en", pwm_en, 1'b0);
        chk("R1", "pwm_force_hi", pwm_force_hi, 1'b0);
        chk("R1", "out_float", out_float, 1'b1);
        chk("R1", "ot_fault_n", ot_fault_n, 1'b1);
        rst_n = 1'b1; cmp_on = 1'b1;
        at_neg();
        chk("R1", "pwm_en after release", pwm_en, 1'b0);

        // R3: between thresholds stays in shutdown
        prim_code = 8'd45; wait_n(5);
        chk("R3", "pwm_en between thresholds", pwm_en, 1'b0);

        // R4: release without wake condition goes to sleep
        sleep_code = 8'd100; prim_code = 8'd120; sec_code = 8'd50; wait_n(5);
        chk("R4", "pwm_force_hi after release into sleep", pwm_force_hi, 1'b0);
        chk("R4", "out_float after release into sleep", out_float, 1'b1);

        // R8: equal to wake level does not wake, one above does
        prim_code = 8'd128; wait_n(3);
        chk("R8", "pwm_force_hi at wake level", pwm_force_hi, 1'b0);
        prim_code = 8'd129; period_tick = 1'b1;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            at_neg();
            if (pwm_force_hi) n++;
        end
        // R5: exactly 64 ticks of forced drive
        checks++;
        if (n != NPER) begin
            failures++;
            $display("FAIL R5 forced cycles actual=%0d expected=%0d", n, NPER);
        end
        chk("R6", "pwm_en in normal", pwm_en, 1'b1);
        chk("R6", "pwm_force_hi in normal", pwm_force_hi, 1'b0);

        // R7: both below threshold enters sleep next cycle
        prim_code = 8'd80; sec_code = 8'd90; at_neg();
        chk("R7", "pwm_en in sleep", pwm_en, 1'b0);
        chk("R7", "out_float in sleep", out_float, 1'b1);

        // R9: zero threshold wakes and never sleeps
        sleep_code = 8'd0; wait_n(70);
        prim_code = 8'd40; sec_code = 8'd0; wait_n(5);
        chk("R9", "pwm_en with sleep disabled", pwm_en, 1'b1);

        // R10: fault boundary
        prim_code = 8'd197; at_neg();
        chk("R10", "ot_fault_n above fault code", ot_fault_n, 1'b0);
        chk("R10", "pwm_en during fault", pwm_en, 1'b1);
        prim_code = 8'd196; at_neg();
        chk("R10", "ot_fault_n at fault code", ot_fault_n, 1'b1);

        // R2: immediate shutdown with secondary high, fault set before
        prim_code = 8'd200; at_neg();
        prim_code = 8'd35; sec_code = 8'd255; #1;
        chk("R2", "pwm_en same cycle", pwm_en, 1'b0);
        chk("R2", "ot_fault_n same cycle", ot_fault_n, 1'b1);
        chk("R2", "out_float same cycle", out_float, 1'b1);

        // R3: equal to release code stays down; R4: release with wake
        at_neg(); prim_code = 8'd56; sec_code = 8'd0; wait_n(5);
        chk("R3", "pwm_en at release code", pwm_en, 1'b0);
        prim_code = 8'd57; at_neg();
        chk("R4", "pwm_force_hi after wake release", pwm_force_hi, 1'b1);

        // random phase against the model
        for (int blk = 0; blk < 500; blk++) begin
            int r, hold;
            r = $urandom % 16;
            if (r == 0)      prim_code = 8'($urandom % LO);
            else if (r < 3)  prim_code = 8'(LO + $urandom % 30);
            else             prim_code = 8'($urandom % 256);
            sec_code = 8'($urandom % 256);
            if ($urandom % 8 == 0) begin
                case ($urandom % 4)
                    0: sleep_code = 8'd0;
                    1: sleep_code = 8'd60;
                    2: sleep_code = 8'd100;
                    default: sleep_code = 8'd150;
                endcase
            end
            hold = 1 + $urandom % 20;
            for (int k = 0; k < hold; k++) begin
                period_tick = ($urandom % 2 == 0);
                at_neg();
            end
        end
        finish_run();
    end
endmodule